// File: doc/BRIEF.md
# In-band software flow controller

This block handles software (in-band) flow control for one UART channel. It sits between the receive deserializer and the receive FIFO. Each received character is compared with programmed resume and pause codes. Flow-control characters are removed from the data stream and pause or resume the local transmitter. All other characters go on to the FIFO.

On the transmit side, the block watches the receive FIFO fill level against a trigger level. When the level reaches the trigger, it asks the transmitter to insert a pause code. When the level drops back below the trigger, it asks for a resume code. The request can be one character or a pair of characters.

The block can also detect a special character. A special character is stored in the FIFO like normal data, and it raises its own interrupt flag. Character framing, the FIFO and the transmit serializer are outside this block.

Top module: `swfc_ctrl`

## Requirements
- R1: Four 8-bit code registers are written through `cfg_we_i`/`cfg_sel_i`/`cfg_wdata_i`. The select values are 0 = resume code A, 1 = resume code B, 2 = pause code A, 3 = pause code B. All four reset to 0x00. Bit 0 of each code is compared with bit 0 (LSB) of the received character.
- R2: `rx_mode_i` sets how received characters are matched. 1 matches code A only, 2 matches code B only, 3 matches either A or B. A character that equals a pause code counts as pause, even if it also equals a resume code.
- R3: `rx_mode_i` = 4 is pair mode: a code A followed directly by the matching code B forms one pause or resume. A code A is consumed and held as a partial match. If the next character does not complete the pair, the partial match is dropped and that character is handled as a fresh character: it is either a new code A or normal data.
- R4: A character that is part of a flow-control match is not written to the FIFO. Every other received character appears on `fifo_we_o`/`fifo_wdata_o`, unchanged, one cycle after `rx_valid_i`.
- R5: `tx_pause_o` goes high one cycle after a recognised pause and low one cycle after a recognised resume.
- R6: `irq_xoff_o` is set by a recognised pause. It is cleared by a recognised resume or by `stat_rd_i`. If a set and a clear happen in the same cycle, the set wins.
- R7: When `spec_en_i` is high, a character that reaches the FIFO and equals pause code B sets `irq_spec_o`. The character is still written to the FIFO. The flag clears on `stat_rd_i` or when the next character arrives.
- R8: When `fifo_level_i` rises to or above `trig_level_i`, exactly one pause insertion is requested. When the level then falls below the trigger, exactly one resume insertion is requested.
- R9: `tx_mode_i` selects the inserted code: 1 sends code A, 2 sends code B, 3 sends code A then code B. `ins_req_o` and `ins_code_o` hold until `ins_ack_i`. With `tx_mode_i` = 0, no request is raised.
- R10: `rx_mode_i` values 0, 5, 6 and 7 turn receive matching off. Every character then goes to the FIFO, and the pause output and pause flag are not affected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Code register write strobe |
| cfg_sel_i | input | 2 | Code register select |
| cfg_wdata_i | input | 8 | Code register write data |
| rx_mode_i | input | 3 | Receive match mode |
| tx_mode_i | input | 2 | Transmit insertion mode |
| spec_en_i | input | 1 | Special character detect enable |
| rx_valid_i | input | 1 | Received character strobe |
| rx_data_i | input | 8 | Received character |
| stat_rd_i | input | 1 | Interrupt status read strobe |
| fifo_level_i | input | LVL_W | Receive FIFO fill level |
| trig_level_i | input | LVL_W | Receive FIFO trigger level |
| fifo_we_o | output | 1 | FIFO write strobe |
| fifo_wdata_o | output | 8 | FIFO write data |
| tx_pause_o | output | 1 | Transmitter pause |
| ins_req_o | output | 1 | Code insertion request |
| ins_code_o | output | 8 | Code to insert |
| ins_ack_i | input | 1 | Insertion accepted |
| irq_xoff_o | output | 1 | Pause received flag |
| irq_spec_o | output | 1 | Special character flag |

## Verification
The assertions check these on every cycle:
- FIFO writes only follow a received strobe, and a flow-control match never produces a write.
- A pause or resume hit moves `tx_pause_o` and `irq_xoff_o` on the next cycle.
- A raised special flag always comes with a FIFO write.
- An insertion request holds until it is acknowledged.

Only the bench scenarios can show the rest: the reset code values, the choice of which code matches in each mode, a dropped partial pair followed by data, one request per trigger crossing, and the two-character insertion order.

// File: rtl/swfc_pkg.sv
package swfc_pkg;
  localparam int unsigned CODE_W = 8;

  localparam logic [2:0] RXM_OFF    = 3'd0;
  localparam logic [2:0] RXM_SET_A  = 3'd1;
  localparam logic [2:0] RXM_SET_B  = 3'd2;
  localparam logic [2:0] RXM_EITHER = 3'd3;
  localparam logic [2:0] RXM_PAIR   = 3'd4;

  localparam logic [1:0] TXM_OFF   = 2'd0;
  localparam logic [1:0] TXM_SET_A = 2'd1;
  localparam logic [1:0] TXM_SET_B = 2'd2;
  localparam logic [1:0] TXM_PAIR  = 2'd3;

  typedef enum logic [1:0] {PEND_NONE, PEND_ON, PEND_OFF} pend_e;
  typedef enum logic [1:0] {SEQ_IDLE, SEQ_FIRST, SEQ_SECOND} seq_e;

  typedef struct packed {
    logic [CODE_W-1:0] on_a;
    logic [CODE_W-1:0] on_b;
    logic [CODE_W-1:0] off_a;
    logic [CODE_W-1:0] off_b;
  } codes_t;
endpackage

// File: rtl/swfc_rx_match.sv
module swfc_rx_match
  import swfc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [CODE_W-1:0] data_i,
  input  logic [2:0]        mode_i,
  input  logic              spec_en_i,
  input  codes_t            codes_i,
  output logic              on_hit_o,
  output logic              off_hit_o,
  output logic              spec_hit_o,
  output logic              fifo_we_o,
  output logic [CODE_W-1:0] fifo_wdata_o
);
  pend_e pend_q, pend_d;
  logic  consume, pass;

  always_comb begin
    on_hit_o  = 1'b0;
    off_hit_o = 1'b0;
    consume   = 1'b0;
    pend_d    = (mode_i == RXM_PAIR) ? pend_q : PEND_NONE;
    if (valid_i) begin
      case (mode_i)
        RXM_SET_A: begin
          off_hit_o = (data_i == codes_i.off_a);
          on_hit_o  = !off_hit_o && (data_i == codes_i.on_a);
        end
        RXM_SET_B: begin
          off_hit_o = (data_i == codes_i.off_b);
          on_hit_o  = !off_hit_o && (data_i == codes_i.on_b);
        end
        RXM_EITHER: begin
          off_hit_o = (data_i == codes_i.off_a) || (data_i == codes_i.off_b);
          on_hit_o  = !off_hit_o &&
                      ((data_i == codes_i.on_a) || (data_i == codes_i.on_b));
        end
        RXM_PAIR: begin
          pend_d = PEND_NONE;
          if (pend_q == PEND_OFF && data_i == codes_i.off_b)     off_hit_o = 1'b1;
          else if (pend_q == PEND_ON && data_i == codes_i.on_b)  on_hit_o  = 1'b1;
          else if (data_i == codes_i.off_a)                      pend_d    = PEND_OFF;
          else if (data_i == codes_i.on_a)                       pend_d    = PEND_ON;
          consume = (pend_d != PEND_NONE);
        end
        default: ;
      endcase
    end
  end

  assign pass       = valid_i && !consume && !on_hit_o && !off_hit_o;
  assign spec_hit_o = pass && spec_en_i && (data_i == codes_i.off_b);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q       <= PEND_NONE;
      fifo_we_o    <= 1'b0;
      fifo_wdata_o <= '0;
    end else begin
      pend_q    <= pend_d;
      fifo_we_o <= pass;
      if (pass) fifo_wdata_o <= data_i;
    end
  end

  assert_we_after_valid_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_we_o |-> $past(valid_i));
  assert_flow_consumed_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (on_hit_o || off_hit_o) |=> !fifo_we_o);
  assert_single_hit_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(on_hit_o && off_hit_o));
endmodule

// File: rtl/swfc_flags.sv
module swfc_flags (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic valid_i,
  input  logic on_hit_i,
  input  logic off_hit_i,
  input  logic spec_hit_i,
  input  logic stat_rd_i,
  input  logic fifo_we_i,
  output logic tx_pause_o,
  output logic irq_xoff_o,
  output logic irq_spec_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_pause_o <= 1'b0;
      irq_xoff_o <= 1'b0;
      irq_spec_o <= 1'b0;
    end else begin
      if (off_hit_i)     tx_pause_o <= 1'b1;
      else if (on_hit_i) tx_pause_o <= 1'b0;

      if (off_hit_i)                  irq_xoff_o <= 1'b1;
      else if (on_hit_i || stat_rd_i) irq_xoff_o <= 1'b0;

      if (spec_hit_i)                irq_spec_o <= 1'b1;
      else if (valid_i || stat_rd_i) irq_spec_o <= 1'b0;
    end
  end

  assert_pause_set_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    off_hit_i |=> tx_pause_o && irq_xoff_o);
  assert_resume_clr_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    on_hit_i |=> !tx_pause_o && !irq_xoff_o);
  assert_rd_clr_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_rd_i && !off_hit_i |=> !irq_xoff_o);
  assert_spec_with_write_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_spec_o) |-> fifo_we_i);
endmodule

// File: rtl/swfc_tx_seq.sv
module swfc_tx_seq
  import swfc_pkg::*;
#(
  parameter int unsigned LVL_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        mode_i,
  input  logic [LVL_W-1:0]  level_i,
  input  logic [LVL_W-1:0]  trig_i,
  input  codes_t            codes_i,
  input  logic              ack_i,
  output logic              req_o,
  output logic [CODE_W-1:0] code_o
);
  seq_e       seq_q;
  logic       off_q;   // current request is a pause
  logic       sent_q;  // pause issued, resume still owed
  logic [1:0] mode_q;
  logic       above;

  assign above = (level_i >= trig_i);
  assign req_o = (seq_q != SEQ_IDLE);

  always_comb begin
    if (seq_q == SEQ_SECOND || mode_q == TXM_SET_B)
      code_o = off_q ? codes_i.off_b : codes_i.on_b;
    else
      code_o = off_q ? codes_i.off_a : codes_i.on_a;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seq_q  <= SEQ_IDLE;
      off_q  <= 1'b0;
      sent_q <= 1'b0;
      mode_q <= TXM_OFF;
    end else begin
      case (seq_q)
        SEQ_IDLE: if (mode_i != TXM_OFF) begin
          if (above && !sent_q) begin
            seq_q <= SEQ_FIRST; off_q <= 1'b1; sent_q <= 1'b1; mode_q <= mode_i;
          end else if (!above && sent_q) begin
            seq_q <= SEQ_FIRST; off_q <= 1'b0; sent_q <= 1'b0; mode_q <= mode_i;
          end
        end
        SEQ_FIRST:  if (ack_i) seq_q <= (mode_q == TXM_PAIR) ? SEQ_SECOND : SEQ_IDLE;
        SEQ_SECOND: if (ack_i) seq_q <= SEQ_IDLE;
        default:    seq_q <= SEQ_IDLE;
      endcase
    end
  end

  assert_req_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o && !ack_i |=> req_o && $stable(off_q));
  assert_off_mode_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_o && mode_i == TXM_OFF |=> !req_o);
  assert_second_pair_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seq_q == SEQ_SECOND |-> mode_q == TXM_PAIR);
endmodule

// File: rtl/swfc_ctrl.sv
module swfc_ctrl
  import swfc_pkg::*;
#(
  parameter int unsigned FIFO_DEPTH = 16,
  localparam int unsigned LVL_W = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [1:0]        cfg_sel_i,
  input  logic [7:0]        cfg_wdata_i,
  input  logic [2:0]        rx_mode_i,
  input  logic [1:0]        tx_mode_i,
  input  logic              spec_en_i,
  input  logic              rx_valid_i,
  input  logic [7:0]        rx_data_i,
  input  logic              stat_rd_i,
  input  logic [LVL_W-1:0]  fifo_level_i,
  input  logic [LVL_W-1:0]  trig_level_i,
  output logic              fifo_we_o,
  output logic [7:0]        fifo_wdata_o,
  output logic              tx_pause_o,
  output logic              ins_req_o,
  output logic [7:0]        ins_code_o,
  input  logic              ins_ack_i,
  output logic              irq_xoff_o,
  output logic              irq_spec_o
);
  localparam int unsigned N_CODES = 4;

  logic [CODE_W-1:0] code_q [N_CODES];
  codes_t            codes;
  logic              on_hit, off_hit, spec_hit;

  for (genvar i = 0; i < N_CODES; i++) begin : g_code
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  code_q[i] <= '0;
      else if (cfg_we_i && cfg_sel_i == 2'(i))      code_q[i] <= cfg_wdata_i;
    end
  end

  assign codes = '{on_a: code_q[0], on_b: code_q[1], off_a: code_q[2], off_b: code_q[3]};

  swfc_rx_match u_match (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .valid_i      (rx_valid_i),
    .data_i       (rx_data_i),
    .mode_i       (rx_mode_i),
    .spec_en_i    (spec_en_i),
    .codes_i      (codes),
    .on_hit_o     (on_hit),
    .off_hit_o    (off_hit),
    .spec_hit_o   (spec_hit),
    .fifo_we_o    (fifo_we_o),
    .fifo_wdata_o (fifo_wdata_o)
  );

  swfc_flags u_flags (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .valid_i    (rx_valid_i),
    .on_hit_i   (on_hit),
    .off_hit_i  (off_hit),
    .spec_hit_i (spec_hit),
    .stat_rd_i  (stat_rd_i),
    .fifo_we_i  (fifo_we_o),
    .tx_pause_o (tx_pause_o),
    .irq_xoff_o (irq_xoff_o),
    .irq_spec_o (irq_spec_o)
  );

  swfc_tx_seq #(.LVL_W(LVL_W)) u_tx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .mode_i  (tx_mode_i),
    .level_i (fifo_level_i),
    .trig_i  (trig_level_i),
    .codes_i (codes),
    .ack_i   (ins_ack_i),
    .req_o   (ins_req_o),
    .code_o  (ins_code_o)
  );

  assert_mode_off_no_pause_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_mode_i == RXM_OFF || rx_mode_i > RXM_PAIR) && rx_valid_i |=> fifo_we_o);
endmodule

// File: tb/tb_swfc_ctrl.sv
module tb_swfc_ctrl;
  localparam int unsigned LVL_W = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 0; logic [1:0] cfg_sel = 0; logic [7:0] cfg_wdata = 0;
  logic [2:0] rx_mode = 0; logic [1:0] tx_mode = 0; logic spec_en = 0;
  logic rx_valid = 0; logic [7:0] rx_data = 0; logic stat_rd = 0;
  logic [LVL_W-1:0] level = 0, trig = 8;
  logic ins_ack = 0;
  logic fifo_we, tx_pause, ins_req, irq_xoff, irq_spec;
  logic [7:0] fifo_wdata, ins_code;

  int checks = 0, errors = 0;
  bit done = 0;

  // model state
  logic [7:0] m_code [4];
  int  m_pend = 0;  // 0 none, 1 resume half, 2 pause half
  bit  m_pause = 0, m_ixoff = 0, m_ispec = 0, m_we = 0;
  logic [7:0] m_data = 0;

  always #10 clk = ~clk;

  swfc_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_sel_i(cfg_sel),
    .cfg_wdata_i(cfg_wdata), .rx_mode_i(rx_mode), .tx_mode_i(tx_mode),
    .spec_en_i(spec_en), .rx_valid_i(rx_valid), .rx_data_i(rx_data),
    .stat_rd_i(stat_rd), .fifo_level_i(level), .trig_level_i(trig),
    .fifo_we_o(fifo_we), .fifo_wdata_o(fifo_wdata), .tx_pause_o(tx_pause),
    .ins_req_o(ins_req), .ins_code_o(ins_code), .ins_ack_i(ins_ack),
    .irq_xoff_o(irq_xoff), .irq_spec_o(irq_spec)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_rx(input string tag);
    chk(fifo_we == m_we, {tag, " we"}, fifo_we, m_we);
    if (m_we) chk(fifo_wdata == m_data, {tag, " data"}, fifo_wdata, m_data);
    chk(tx_pause == m_pause, {tag, " pause"}, tx_pause, m_pause);
    chk(irq_xoff == m_ixoff, {tag, " irq_xoff"}, irq_xoff, m_ixoff);
    chk(irq_spec == m_ispec, {tag, " irq_spec"}, irq_spec, m_ispec);
  endtask

  task automatic set_code(input int sel, input logic [7:0] v);
    cfg_we = 1; cfg_sel = 2'(sel); cfg_wdata = v; m_code[sel] = v;
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic set_rx_mode(input logic [2:0] m);
    rx_mode = m;
    if (m != 3'd4) m_pend = 0;
    @(negedge clk); m_we = 0;
  endtask

  // expected result of one received byte, per R2..R7, R10
  task automatic model_byte(input logic [7:0] b);
    bit on = 0, off = 0, cons = 0;
    case (rx_mode)
      3'd1: begin off = (b == m_code[2]); on = !off && b == m_code[0]; end
      3'd2: begin off = (b == m_code[3]); on = !off && b == m_code[1]; end
      3'd3: begin off = (b == m_code[2] || b == m_code[3]);
                  on = !off && (b == m_code[0] || b == m_code[1]); end
      3'd4: begin
        int prev = m_pend;
        m_pend = 0;
        if (prev == 2 && b == m_code[3]) off = 1;
        else if (prev == 1 && b == m_code[1]) on = 1;
        else if (b == m_code[2]) begin m_pend = 2; cons = 1; end
        else if (b == m_code[0]) begin m_pend = 1; cons = 1; end
      end
      default: ;
    endcase
    m_we = !(on || off || cons);
    m_data = b;
    if (off) begin m_pause = 1; m_ixoff = 1; end
    else if (on) begin m_pause = 0; m_ixoff = 0; end
    m_ispec = m_we && spec_en && (b == m_code[3]);
  endtask

  task automatic send_byte(input logic [7:0] b, input string tag);
    rx_valid = 1; rx_data = b;
    model_byte(b);
    @(negedge clk); rx_valid = 0;
    check_rx(tag);
    m_we = 0;
  endtask

  task automatic status_read(input string tag);
    stat_rd = 1;
    @(negedge clk); stat_rd = 0;
    m_ixoff = 0; m_ispec = 0;
    check_rx(tag);
  endtask

  task automatic check_req(input bit r, input logic [7:0] c, input string tag);
    chk(ins_req == r, {tag, " req"}, ins_req, r);
    if (r) chk(ins_code == c, {tag, " code"}, ins_code, c);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 4; i++) m_code[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // reset state
    chk(!fifo_we && !tx_pause && !irq_xoff && !irq_spec && !ins_req, "R1 reset outputs",
        {fifo_we, tx_pause, irq_xoff, irq_spec, ins_req}, 0);
    // R1: codes reset to 0x00; pause wins over resume (R2)
    set_rx_mode(3'd1);
    send_byte(8'h00, "R1 R2 reset code pause");
    chk(tx_pause == 1'b1, "R1 zero code matched", tx_pause, 1);
    send_byte(8'h01, "R4 data passes");

    set_code(0, 8'h11); set_code(1, 8'h12); set_code(2, 8'h13); set_code(3, 8'h93);
    send_byte(8'h11, "R5 resume A");
    send_byte(8'h93, "R2 code B ignored in mode A");
    set_rx_mode(3'd2);
    send_byte(8'h13, "R2 code A ignored in mode B");
    send_byte(8'h93, "R2 pause B");
    status_read("R6 status read clears");
    send_byte(8'h93, "R6 pause again");
    send_byte(8'h12, "R6 resume clears flag");
    set_rx_mode(3'd3);
    send_byte(8'h13, "R2 either pause A");
    send_byte(8'h12, "R2 either resume B");

    set_rx_mode(3'd4);
    send_byte(8'h13, "R3 pair first half");
    send_byte(8'h93, "R3 pair completes pause");
    send_byte(8'h11, "R3 resume first half");
    send_byte(8'h55, "R3 mismatch passes");
    chk(tx_pause == 1'b1, "R3 broken pair no resume", tx_pause, 1);
    send_byte(8'h11, "R3 resume half");
    send_byte(8'h13, "R3 restart as pause half");
    send_byte(8'h93, "R3 restarted pair completes");
    send_byte(8'h11, "R3 resume half");
    send_byte(8'h12, "R3 resume completes");

    set_rx_mode(3'd1);
    spec_en = 1;
    send_byte(8'h93, "R7 special stored");
    send_byte(8'h20, "R7 next char clears");
    send_byte(8'h93, "R7 special again");
    status_read("R7 read clears special");

    set_rx_mode(3'd0);
    send_byte(8'h13, "R10 off mode pass pause code");
    set_rx_mode(3'd6);
    send_byte(8'h13, "R10 reserved mode pass");

    // constrained random receive
    for (int n = 0; n < 600; n++) begin
      if (n % 40 == 0) begin
        set_rx_mode(3'($urandom_range(0, 7)));
        spec_en = 1'($urandom_range(0, 1));
      end
      case ($urandom_range(0, 9))
        0: status_read("R6 R7 random read");
        1: begin @(negedge clk); check_rx("R4 idle"); end
        2, 3, 4, 5: send_byte(m_code[$urandom_range(0, 3)], "R2 R3 random code");
        default: send_byte(8'($urandom), "R4 random data");
      endcase
    end

    // transmit side
    tx_mode = 2'd3; trig = 8; level = 4;
    repeat (2) @(negedge clk);
    check_req(0, 0, "R8 below trigger idle");
    level = 8;
    @(negedge clk);
    check_req(1, m_code[2], "R8 R9 pause first");
    repeat (2) @(negedge clk);
    check_req(1, m_code[2], "R9 held until ack");
    ins_ack = 1;
    @(negedge clk);
    check_req(1, m_code[3], "R9 pause second");
    @(negedge clk); ins_ack = 0;
    check_req(0, 0, "R9 pair done");
    level = 12;
    repeat (3) @(negedge clk);
    check_req(0, 0, "R8 once per crossing");
    level = 7;
    @(negedge clk);
    check_req(1, m_code[0], "R8 resume first");
    ins_ack = 1;
    @(negedge clk);
    check_req(1, m_code[1], "R9 resume second");
    @(negedge clk); ins_ack = 0;
    check_req(0, 0, "R9 resume done");
    tx_mode = 2'd2; level = 9;
    @(negedge clk);
    check_req(1, m_code[3], "R9 single B pause");
    ins_ack = 1;
    @(negedge clk); ins_ack = 0;
    check_req(0, 0, "R9 single done");
    tx_mode = 2'd1; level = 2;
    @(negedge clk);
    check_req(1, m_code[0], "R9 single A resume");
    ins_ack = 1;
    @(negedge clk); ins_ack = 0;
    tx_mode = 2'd0; level = 15;
    repeat (3) @(negedge clk);
    check_req(0, 0, "R9 mode off no request");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule